// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block merges the interrupt events of a set of DMA channels into one interrupt line toward the host. Every channel owns a pending bit and a mute bit. When an event arrives on a channel that is not muted, the block latches the pending bit and, in the same clock, sets that channel's mute bit by itself. Further events from that channel are then held off until software clears the mute bit again, once it has finished with the channel.

A global control word carries a master enable and a summary flag, which is the OR of all pending bits. Reading the control word returns its current value and clears the master enable in the same cycle. Several handler threads that race on the interrupt can therefore sort the outcome from the value they read. Enable 1 with summary 1 means a valid interrupt, and this reader owns the handling. Enable 1 with summary 0 means a spurious interrupt. Enable 0 means another reader already took it. Software sets the master enable again when it has finished.

Register map, one 32-bit word per address. Address 0 is control: bit 0 is the master enable (read/write), bit 1 is the summary flag (read-only). Address 1 holds the pending bits, bit i for channel i; writing 1 to a bit clears it. Address 2 holds the mute bits, bit i for channel i, and a write loads them directly. Address 3 reads 0. Read data is combinational during the read strobe. Register side effects take place at the rising clock edge.

Top module: `dma_irq_agg`

## Requirements
- R1: An event pulse on channel i whose mute bit is 0 sets pending bit i (address 1, bit i) at the next clock edge.
- R2: The clock edge at which an event sets pending bit i also sets mute bit i (address 2, bit i), with no register write involved.
- R3: While mute bit i is 1, events on channel i leave pending bit i unchanged.
- R4: A write to address 2 loads the mute bits from the write data. Clearing a mute bit re-enables events on that channel. An event accepted in the same cycle still sets its mute bit.
- R5: A read of address 0 returns the master enable in bit 0 and the OR of all pending bits in bit 1, with all other bits 0. Writing address 0 loads the master enable from write data bit 0.
- R6: A read of address 0 returns the master enable value held before the read, and clears the master enable at that clock edge. A write to address 0 in the same cycle takes priority.
- R7: irqOut is 1 exactly when the master enable is 1 and at least one pending bit is 1.
- R8: Writing 1 to a bit of address 1 clears that pending bit. If an unmuted event on the same channel arrives in the same cycle, the bit stays set.
- R9: After reset, all pending bits, mute bits and the master enable are 0, and irqOut is 0.
- R10: Read-data bits at or above the channel count read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Register write data |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regRdData | output | 32 | Register read data, valid while regRd is high |
| chanEvent | input | NUM_CH | Per-channel interrupt event pulses |
| irqOut | output | 1 | Aggregated interrupt to the host |

## Verification
The hardest situations to reach are those where software and hardware act on the same bit in the same clock. One is a pending-bit clear that coincides with an event on an unmuted channel. Another is the same clear coinciding with an event on a muted channel. The bench drives the register write strobe and the event pulses on the same falling edge to line these collisions up exactly. For the unmuted case, it first clears the mute bit with a separate write. The bench also sweeps every channel pattern through the full cycle of latch, mute and claim-by-read.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MUTE = 2'd2;

  typedef struct packed {
    logic ctrlRd;
    logic ctrlWr;
    logic pendWr;
    logic muteWr;
    logic selCtrl;
    logic selPend;
    logic selMute;
  } regStrobe_t;
endpackage

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  output regStrobe_t        strobes
);
  logic hitCtrl, hitPend, hitMute;

  always_comb begin
    hitCtrl = (regAddr == ADDR_CTRL);
    hitPend = (regAddr == ADDR_PEND);
    hitMute = (regAddr == ADDR_MUTE);
    strobes.ctrlRd  = regRd & hitCtrl;
    strobes.ctrlWr  = regWr & hitCtrl;
    strobes.pendWr  = regWr & hitPend;
    strobes.muteWr  = regWr & hitMute;
    strobes.selCtrl = regRd & hitCtrl;
    strobes.selPend = regRd & hitPend;
    strobes.selMute = regRd & hitMute;
  end
endmodule

// File: rtl/dma_irq_datapath.sv
module dma_irq_datapath
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] chanEvent,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] mute;
  logic [NUM_CH-1:0] accept;
  logic              masterEn;
  logic              summary;

  always_comb begin
    accept  = chanEvent & ~mute;
    summary = |pend;
    irqOut  = masterEn & summary;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pend[i] <= 1'b0;
        mute[i] <= 1'b0;
      end else begin
        pend[i] <= accept[i] | (pend[i] & ~(strobes.pendWr & wrData[i]));
        mute[i] <= accept[i] | (strobes.muteWr ? wrData[i] : mute[i]);
      end
    end

    AST_EVT_LATCHES_BOTH: assert property (@(posedge clk) disable iff (!rstN)
      $past(chanEvent[i] && !mute[i]) |-> (pend[i] && mute[i])); // R2
    AST_MUTED_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
      $past(mute[i] && !pend[i]) |-> !pend[i]); // R3
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.pendWr && wrData[i] && !(chanEvent[i] && !mute[i])) |-> !pend[i]); // R8
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               masterEn <= 1'b0;
    else if (strobes.ctrlWr) masterEn <= wrData[0];
    else if (strobes.ctrlRd) masterEn <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (strobes.selCtrl) rdData = {{(DATA_W-2){1'b0}}, summary, masterEn};
    else if (strobes.selPend) rdData = DATA_W'(pend);
    else if (strobes.selMute) rdData = DATA_W'(mute);
  end

  AST_READ_CLAIMS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.ctrlRd && !strobes.ctrlWr) |-> !irqOut); // R6
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (rdData[1] || !strobes.selCtrl)); // R7
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWrData,
  input  logic              regRd,
  input  logic              regWr,
  output logic [31:0]       regRdData,
  input  logic [NUM_CH-1:0] chanEvent,
  output logic              irqOut
);
  regStrobe_t strobes;

  dma_irq_ctrl u_ctrl (
    .regAddr (regAddr),
    .regRd   (regRd),
    .regWr   (regWr),
    .strobes (strobes)
  );

  dma_irq_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .chanEvent (chanEvent),
    .rdData    (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/dma_irq_agg_bench.sv
module dma_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam logic [31:0] ALL = (32'd1 << NCH) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic regRd = 1'b0;
  logic regWr = 1'b0;
  logic [31:0] regRdData;
  logic [NCH-1:0] chanEvent = '0;
  logic irqOut;
  int testCount = 0;
  int failCount = 0;
  int cycles = 0;

  dma_irq_agg #(.NUM_CH(NCH)) u_dma_irq_agg (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regRd(regRd), .regWr(regWr), .regRdData(regRdData),
    .chanEvent(chanEvent), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failCount++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] p);
    @(negedge clk);
    chanEvent = p;
    @(negedge clk);
    chanEvent = '0;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    check("R9 irq", {31'b0, irqOut}, 32'd0);
    regRead(2'd1, d); check("R9 pending", d, 32'd0);
    regRead(2'd2, d); check("R9 mute", d, 32'd0);
    regRead(2'd0, d); check("R9 ctrl", d, 32'd0);

    for (int p = 1; p < (1 << NCH); p++) begin
      regWrite(2'd2, 32'd0);
      regWrite(2'd1, ALL);
      pulse(NCH'(p));
      regRead(2'd1, d); check("R1 pending latched", d, 32'(p));
      regRead(2'd2, d); check("R2 mute auto-set", d, 32'(p));
      regRead(2'd0, d); check("R5 ctrl summary", d, 32'd2);
      regWrite(2'd0, 32'd1);
      #1 check("R7 irq asserted", {31'b0, irqOut}, 32'd1);
      regRead(2'd0, d); check("R6 first reader valid", d, 32'd3);
      #1 check("R7 irq dropped after claim", {31'b0, irqOut}, 32'd0);
      regRead(2'd0, d); check("R6 second reader handled", d, 32'd2);
      regWrite(2'd1, ALL);
      pulse(NCH'(ALL));
      regRead(2'd1, d); check("R3 muted channels blocked", d, ALL & ~32'(p));
      regRead(2'd2, d); check("R4 mute includes new accepts", d, ALL);
      check("R10 upper bits zero", d >> NCH, 32'd0);
    end

    // R4 mute loaded by write
    regWrite(2'd2, 32'h5);
    regRead(2'd2, d); check("R4 mute write", d, 32'h5);
    // R7 spurious: enable set, no pending
    regWrite(2'd1, ALL);
    regWrite(2'd0, 32'd1);
    #1 check("R7 no irq without pending", {31'b0, irqOut}, 32'd0);
    regRead(2'd0, d); check("R5 spurious read", d, 32'd1);

    // R8 same-cycle clear and unmuted event: event wins
    regWrite(2'd2, 32'd0);
    pulse(4'b0001);
    regWrite(2'd2, 32'd0);
    @(negedge clk);
    regAddr = 2'd1; regWrData = 32'd1; regWr = 1'b1; chanEvent = 4'b0001;
    @(negedge clk);
    regWr = 1'b0; chanEvent = '0;
    regRead(2'd1, d); check("R8 event beats clear", d, 32'd1);
    // R8 same-cycle clear and muted event: clear wins
    @(negedge clk);
    regAddr = 2'd1; regWrData = 32'd1; regWr = 1'b1; chanEvent = 4'b0001;
    @(negedge clk);
    regWr = 1'b0; chanEvent = '0;
    regRead(2'd1, d); check("R8 muted event loses", d, 32'd0);
    // R6 write priority over read in same cycle
    @(negedge clk);
    regAddr = 2'd0; regWrData = 32'd1; regWr = 1'b1; regRd = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0;
    regRead(2'd0, d); check("R6 write wins over read clear", d, 32'd1);
    // R10 unmapped address
    regRead(2'd3, d); check("R10 unmapped reads zero", d, 32'd0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule